// File: doc/BRIEF.md
# Optical Link Reset Bridge

This block carries the PCIe fundamental reset over a fibre link that has no sideband wires. One copy sits at each end of the link, and a role input picks how that copy behaves. At the upstream end, the host's active-low reset input controls the optical module's transmit-disable pin. The laser stays dark for as long as reset is held. At the downstream end, the block watches the module's loss-of-signal output. It debounces that signal and turns it into an active-low reset for every device on the local board.

Both asynchronous inputs pass through a two-flop synchroniser before any logic uses them. At the downstream end, a loss-of-signal change must stay stable for a programmable number of cycles before it counts. After the link comes back, the local reset is held for a further programmable time before it is released. A card-presence signal is driven locally at both ends, and no reference clock crosses the link. Because every output is registered, each delay below is an exact number of clock edges.

Top module: `fiber_rst_bridge`

## Requirements
- R1: While `rst_n` is low, `tx_disable_o` is 1, `perst_n_o` is 0 and `prsnt_n_o` is 1.
- R2: With `role_i` = 1 (downstream), a rise of `los_i` (1 = signal lost) that stays stable pulls `perst_n_o` low exactly SYNC_STAGES + DEBOUNCE_CYCLES + 2 clock edges after the change.
- R3: A change of `los_i` that lasts fewer than DEBOUNCE_CYCLES cycles has no effect on `perst_n_o`, in either direction.
- R4: With `role_i` = 1, a stable fall of `los_i` releases `perst_n_o` exactly SYNC_STAGES + DEBOUNCE_CYCLES + HOLD_CYCLES + 1 edges after the change. If the filtered loss returns during the hold time, `perst_n_o` stays low and the hold time starts again once the loss clears.
- R5: With `role_i` = 1, `tx_disable_o` drops to 0 at the first edge after reset and does not depend on `los_i`.
- R6: With `role_i` = 0 (upstream), `tx_disable_o` equals the inverse of `perst_n_i` delayed by SYNC_STAGES + 1 edges. It stays 1 from reset until the synchronised input says otherwise.
- R7: With `role_i` = 0, `perst_n_o` follows `perst_n_i` with the same SYNC_STAGES + 1 edge delay and no debounce. A single-cycle pulse therefore passes through.
- R8: With `role_i` = 0, `los_i` has no effect on either output.
- R9: `prsnt_n_o` is 0 from the first edge after reset in both roles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running local clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously and is released synchronously |
| role_i | input | 1 | 0 = upstream end, 1 = downstream end; static while out of reset |
| perst_n_i | input | 1 | Asynchronous active-low reset from the host (upstream role) |
| los_i | input | 1 | Asynchronous loss-of-signal from the optical module (downstream role) |
| tx_disable_o | output | 1 | Transmit-disable to the optical module; 1 turns the laser off |
| perst_n_o | output | 1 | Active-low reset to the local devices |
| prsnt_n_o | output | 1 | Active-low card-presence signal, generated locally |

## Verification
The bound checker watches several properties on every cycle:
- the filtered loss never flips until the synchronised input has differed from it for at least DEBOUNCE_CYCLES cycles;
- a downstream reset release is always preceded by at least HOLD_CYCLES cycles of clear filtered loss;
- the filtered loss forces the reset output low two edges later;
- in the upstream role, the laser and reset outputs stay complementary;
- presence and the downstream laser stay on after reset.

Only the bench scenarios can show the exact end-to-end edge counts from a pin change to an output change. They also cover sub-threshold glitches in both directions, the hold restart when the link drops again during the hold time, and the fact that loss of signal is ignored in the upstream role.

// File: rtl/fsrb_pkg.sv
package fsrb_pkg;

  typedef enum logic {
    ROLE_UP   = 1'b0,
    ROLE_DOWN = 1'b1
  } fsrb_role_e;

  // Defaults: 4 ms debounce and 100 ms hold at a 250 MHz clock.
  localparam int unsigned DEF_SYNC_STAGES     = 2;
  localparam int unsigned DEF_DEBOUNCE_CYCLES = 1000000;
  localparam int unsigned DEF_HOLD_CYCLES     = 25000000;

  // Bit positions of the asynchronous inputs inside the synchroniser vector.
  localparam int unsigned IDX_PERST = 0;
  localparam int unsigned IDX_LOS   = 1;

endpackage

// File: rtl/fsrb_sync.sv
module fsrb_sync #(
  parameter int unsigned      WIDTH   = 2,
  parameter int unsigned      STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  // Shift one stage per clock; the first stage samples the raw inputs.
  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/fsrb_debounce.sv
module fsrb_debounce #(
  parameter int unsigned CYCLES  = 1000000,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  output logic filt_o
);

  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          filt_q, filt_d;
  logic          cnt_en;

  // The count runs only while the input disagrees with the filtered state.
  always_comb begin
    filt_d = filt_q;
    cnt_d  = '0;
    cnt_en = (cnt_q != '0) || (in_i != filt_q);
    if (in_i != filt_q) begin
      if (cnt_q == LAST) begin
        filt_d = in_i;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      filt_q <= RST_VAL;
    end else begin
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
      filt_q <= filt_d;
    end
  end

  assign filt_o = filt_q;

endmodule

// File: rtl/fsrb_hold.sv
module fsrb_hold #(
  parameter int unsigned CYCLES = 25000000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lost_i,
  output logic reset_act_o
);

  localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          cnt_en;

  // Loss asserts reset at once; a clear link must persist for CYCLES before release.
  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (lost_i) begin
      act_d  = 1'b1;
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (act_q) begin
      cnt_en = 1'b1;
      if (cnt_q == LAST) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= 1'b1;
    end else begin
      if (cnt_en) begin
        cnt_q <= cnt_d;
      end
      act_q <= act_d;
    end
  end

  assign reset_act_o = act_q;

endmodule

// File: rtl/fiber_rst_bridge.sv
module fiber_rst_bridge
  import fsrb_pkg::*;
#(
  parameter int unsigned SYNC_STAGES     = DEF_SYNC_STAGES,
  parameter int unsigned DEBOUNCE_CYCLES = DEF_DEBOUNCE_CYCLES,
  parameter int unsigned HOLD_CYCLES     = DEF_HOLD_CYCLES
) (
  input  logic clk_i,
  input  logic rst_n,
  input  logic role_i,
  input  logic perst_n_i,
  input  logic los_i,
  output logic tx_disable_o,
  output logic perst_n_o,
  output logic prsnt_n_o
);

  localparam int unsigned NUM_ASYNC = 2;
  // Safe values before the chain fills: link lost, host reset asserted.
  localparam logic [NUM_ASYNC-1:0] SYNC_RST = NUM_ASYNC'(1 << IDX_LOS);

  logic [NUM_ASYNC-1:0] async_raw;
  logic [NUM_ASYNC-1:0] async_sync;
  logic                 los_sync;
  logic                 perst_n_sync;
  logic                 los_filt;
  logic                 ds_reset_act;
  fsrb_role_e           role;

  logic tx_dis_q, tx_dis_d;
  logic perst_n_q, perst_n_d;
  logic prsnt_n_q;

  assign role = fsrb_role_e'(role_i);

  always_comb begin
    async_raw            = '0;
    async_raw[IDX_PERST] = perst_n_i;
    async_raw[IDX_LOS]   = los_i;
  end

  fsrb_sync #(
    .WIDTH  (NUM_ASYNC),
    .STAGES (SYNC_STAGES),
    .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .d_i   (async_raw),
    .q_o   (async_sync)
  );

  assign los_sync     = async_sync[IDX_LOS];
  assign perst_n_sync = async_sync[IDX_PERST];

  fsrb_debounce #(
    .CYCLES (DEBOUNCE_CYCLES),
    .RST_VAL(1'b1)
  ) u_los_db (
    .clk_i (clk_i),
    .rst_ni(rst_n),
    .in_i  (los_sync),
    .filt_o(los_filt)
  );

  fsrb_hold #(
    .CYCLES(HOLD_CYCLES)
  ) u_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .lost_i     (los_filt),
    .reset_act_o(ds_reset_act)
  );

  // Output selection by role.
  always_comb begin
    if (role == ROLE_DOWN) begin
      tx_dis_d  = 1'b0;
      perst_n_d = ~ds_reset_act;
    end else begin
      tx_dis_d  = ~perst_n_sync;
      perst_n_d = perst_n_sync;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      tx_dis_q  <= 1'b1;
      perst_n_q <= 1'b0;
      prsnt_n_q <= 1'b1;
    end else begin
      tx_dis_q  <= tx_dis_d;
      perst_n_q <= perst_n_d;
      prsnt_n_q <= 1'b0;
    end
  end

  assign tx_disable_o = tx_dis_q;
  assign perst_n_o    = perst_n_q;
  assign prsnt_n_o    = prsnt_n_q;

endmodule

// File: rtl/fsrb_checker.sv
module fsrb_checker #(
  parameter int unsigned DEBOUNCE_CYCLES = 1000000,
  parameter int unsigned HOLD_CYCLES     = 25000000
) (
  input logic clk_i,
  input logic rst_n,
  input logic role_i,
  input logic tx_disable_o,
  input logic perst_n_o,
  input logic prsnt_n_o,
  input logic los_sync,
  input logic los_filt
);

  logic        armed_q;
  logic [31:0] diff_run_q;
  logic [31:0] low_run_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      diff_run_q <= '0;
      low_run_q  <= '0;
    end else begin
      armed_q <= 1'b1;
      if (los_sync == los_filt) begin
        diff_run_q <= '0;
      end else if (diff_run_q != '1) begin
        diff_run_q <= diff_run_q + 1'b1;
      end
      if (los_filt) begin
        low_run_q <= '0;
      end else if (low_run_q != '1) begin
        low_run_q <= low_run_q + 1'b1;
      end
    end
  end

  // R2: filtered loss forces the local reset low two edges later.
  p_perst_while_lost_r2 : assert property (@(posedge clk_i) disable iff (!rst_n)
    (role_i && los_filt) |-> ##2 !perst_n_o);

  // R3: the filtered state flips only after a full debounce window of disagreement.
  p_debounce_min_r3 : assert property (@(posedge clk_i) disable iff (!rst_n)
    !$stable(los_filt) |-> (diff_run_q >= 32'(DEBOUNCE_CYCLES)));

  // R4: release only after the hold time of clear filtered loss.
  p_hold_min_r4 : assert property (@(posedge clk_i) disable iff (!rst_n)
    (role_i && $rose(perst_n_o)) |-> (low_run_q >= 32'(HOLD_CYCLES)));

  // R5: downstream laser stays on.
  p_ds_laser_on_r5 : assert property (@(posedge clk_i) disable iff (!rst_n)
    (armed_q && role_i) |-> !tx_disable_o);

  // R7: upstream laser and local reset move together.
  p_up_pair_r7 : assert property (@(posedge clk_i) disable iff (!rst_n)
    (armed_q && !role_i) |-> (tx_disable_o == !perst_n_o));

  // R9: presence is driven once out of reset.
  p_presence_r9 : assert property (@(posedge clk_i) disable iff (!rst_n)
    armed_q |-> !prsnt_n_o);

endmodule

bind fiber_rst_bridge fsrb_checker #(
  .DEBOUNCE_CYCLES(DEBOUNCE_CYCLES),
  .HOLD_CYCLES    (HOLD_CYCLES)
) u_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_n),
  .role_i      (role_i),
  .tx_disable_o(tx_disable_o),
  .perst_n_o   (perst_n_o),
  .prsnt_n_o   (prsnt_n_o),
  .los_sync    (los_sync),
  .los_filt    (los_filt)
);

// File: tb/fiber_rst_bridge_tb_top.sv
`timescale 1ns/1ps
module fiber_rst_bridge_tb_top;

  localparam int SYNC = 2;
  localparam int DB   = 8;
  localparam int HOLD = 20;
  localparam int LAT_UP      = SYNC + 1;
  localparam int LAT_LOST    = SYNC + DB + 2;
  localparam int LAT_RELEASE = SYNC + DB + HOLD + 1;

  localparam int SIG_TX    = 0;
  localparam int SIG_PERST = 1;

  typedef struct {
    int    sig;
    logic  val;
    int    cyc;
    string req;
  } exp_t;

  logic clk_i = 1'b0;
  logic rst_n, role_i, perst_n_i, los_i;
  logic tx_disable_o, perst_n_o, prsnt_n_o;

  int    cyc = 0;
  int    n_checks = 0;
  int    n_errors = 0;
  exp_t  exp_q[$];
  logic  mon_en = 1'b0;
  logic  last_tx, last_perst;
  string quiet_req = "R1";
  bit    done = 1'b0;

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  fiber_rst_bridge #(
    .SYNC_STAGES    (SYNC),
    .DEBOUNCE_CYCLES(DB),
    .HOLD_CYCLES    (HOLD)
  ) dut_i (
    .clk_i       (clk_i),
    .rst_n       (rst_n),
    .role_i      (role_i),
    .perst_n_i   (perst_n_i),
    .los_i       (los_i),
    .tx_disable_o(tx_disable_o),
    .perst_n_o   (perst_n_o),
    .prsnt_n_o   (prsnt_n_o)
  );

  task automatic check(string req, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic expect_change(int sig, logic val, int lat, string req);
    exp_t e;
    e.sig = sig;
    e.val = val;
    e.cyc = cyc + lat;
    e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic observe(int sig, logic val);
    exp_t e;
    n_checks++;
    if (exp_q.size() == 0) begin
      n_errors++;
      $display("FAIL %s unexpected change of output %0d at cycle %0d: actual %b expected no change",
               quiet_req, sig, cyc, val);
    end else begin
      e = exp_q.pop_front();
      if (e.sig != sig || e.val !== val || e.cyc != cyc) begin
        n_errors++;
        $display("FAIL %s output %0d value %b at cycle %0d: expected output %0d value %b at cycle %0d",
                 e.req, sig, val, cyc, e.sig, e.val, e.cyc);
      end
    end
  endtask

  // Monitor: compares every output transition against the scoreboard queue.
  always @(negedge clk_i) begin
    if (mon_en) begin
      if (tx_disable_o !== last_tx) observe(SIG_TX, tx_disable_o);
      if (perst_n_o !== last_perst) observe(SIG_PERST, perst_n_o);
    end
    last_tx    <= tx_disable_o;
    last_perst <= perst_n_o;
  end

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
  endtask

  initial begin
    int c0;
    rst_n = 1'b0; role_i = 1'b1; los_i = 1'b1; perst_n_i = 1'b0;
    wait_cyc(3);
    check("R1", "tx_disable in reset", tx_disable_o, 1'b1);
    check("R1", "perst_n in reset", perst_n_o, 1'b0);
    check("R1", "prsnt_n in reset", prsnt_n_o, 1'b1);

    // Downstream role
    rst_n = 1'b1;
    mon_en = 1'b1;
    quiet_req = "R2";
    expect_change(SIG_TX, 1'b0, 1, "R5");
    wait_cyc(1);
    check("R9", "presence after reset (downstream)", prsnt_n_o, 1'b0);
    wait_cyc(40);
    check("R2", "reset held while LOS", perst_n_o, 1'b0);

    los_i = 1'b0;
    quiet_req = "R4";
    expect_change(SIG_PERST, 1'b1, LAT_RELEASE, "R4");
    wait_cyc(45);
    check("R4", "released after hold", perst_n_o, 1'b1);

    quiet_req = "R3";
    los_i = 1'b1;
    wait_cyc(DB - 1);
    los_i = 1'b0;
    wait_cyc(30);
    check("R3", "short LOS pulse ignored", perst_n_o, 1'b1);

    quiet_req = "R2";
    los_i = 1'b1;
    expect_change(SIG_PERST, 1'b0, LAT_LOST, "R2");
    wait_cyc(30);
    check("R2", "reset asserted on LOS", perst_n_o, 1'b0);

    quiet_req = "R3";
    los_i = 1'b0;
    wait_cyc(DB - 1);
    los_i = 1'b1;
    wait_cyc(30);
    check("R3", "short LOS clear ignored", perst_n_o, 1'b0);

    // LOS returns during the hold window: no release, hold restarts.
    quiet_req = "R4";
    c0 = cyc;
    los_i = 1'b0;
    wait_cyc(SYNC + DB + 6);
    los_i = 1'b1;
    wait_cyc(40);
    check("R4", "hold aborted by returning LOS", perst_n_o, 1'b0);
    if (cyc - c0 < 0) $display("cycle counter wrapped");

    los_i = 1'b0;
    expect_change(SIG_PERST, 1'b1, LAT_RELEASE, "R4");
    wait_cyc(45);
    check("R4", "release after restarted hold", perst_n_o, 1'b1);
    check("R5", "downstream laser on after LOS activity", tx_disable_o, 1'b0);

    // Upstream role
    mon_en = 1'b0;
    rst_n = 1'b0; role_i = 1'b0; perst_n_i = 1'b0; los_i = 1'b1;
    wait_cyc(3);
    check("R1", "tx_disable in second reset", tx_disable_o, 1'b1);
    rst_n = 1'b1;
    wait_cyc(1);
    mon_en = 1'b1;
    quiet_req = "R6";
    wait_cyc(10);
    check("R6", "laser off while host reset held", tx_disable_o, 1'b1);
    check("R9", "presence after reset (upstream)", prsnt_n_o, 1'b0);

    perst_n_i = 1'b1;
    expect_change(SIG_TX, 1'b0, LAT_UP, "R6");
    expect_change(SIG_PERST, 1'b1, LAT_UP, "R7");
    wait_cyc(10);

    quiet_req = "R8";
    los_i = 1'b0;
    wait_cyc(30);
    los_i = 1'b1;
    wait_cyc(30);
    check("R8", "laser unaffected by LOS", tx_disable_o, 1'b0);
    check("R8", "reset unaffected by LOS", perst_n_o, 1'b1);

    quiet_req = "R7";
    perst_n_i = 1'b0;
    expect_change(SIG_TX, 1'b1, LAT_UP, "R6");
    expect_change(SIG_PERST, 1'b0, LAT_UP, "R7");
    expect_change(SIG_TX, 1'b0, LAT_UP + 1, "R6");
    expect_change(SIG_PERST, 1'b1, LAT_UP + 1, "R7");
    wait_cyc(1);
    perst_n_i = 1'b1;
    wait_cyc(10);

    perst_n_i = 1'b0;
    expect_change(SIG_TX, 1'b1, LAT_UP, "R6");
    expect_change(SIG_PERST, 1'b0, LAT_UP, "R7");
    wait_cyc(10);
    check("R6", "laser off after host reset", tx_disable_o, 1'b1);

    n_checks++;
    if (exp_q.size() != 0) begin
      n_errors++;
      $display("FAIL %s pending transitions: actual %0d expected 0", exp_q[0].req, exp_q.size());
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule